// File: doc/BRIEF.md
# Opcode Cycle Count Stall Controller

This block sits between instruction fetch and execution in an 8-bit microcontroller core. When fetch presents a one-byte opcode together with the instruction's length in bytes, the block looks up how many memory cycles that instruction executes for. It then works out how many more memory cycles are needed than the bytes being fetched would cover, and holds the program counter advance for exactly that many memory-cycle strobes.

A short fixed table covers the instructions whose execution is longer than their fetch. Every other opcode takes as many cycles as it has bytes, so it never stalls. Counting advances only on the memory-cycle strobe, not on every system clock, so the same block works whether a memory cycle lasts one clock or several.

The opcode input is a plain one-cycle pulse with no back-pressure. The stall output is the only flow control. An opcode pulse that arrives while stall is high is dropped, and fetch must not present a new opcode until stall falls.

Top module: `opst_top`

## Requirements
- R1: While reset (`rst_n` low, asynchronous) is active, and in the first cycle after it is released, `stall` is 0, `exec_done` is 0 and `cycles_left` is 0.
- R2: The execution cycle counts are: opcode 13h takes 1 cycle, D4h takes 2, 22h takes 3, A4h takes 9 and 84h takes 10. Any other opcode takes a cycle count equal to its byte count. `op_bytes` values 1, 2 and 3 mean that many bytes, and the value 0 is treated as 1.
- R3: An accepted opcode needs an extra count of max(cycles − bytes, 0). In the cycle after acceptance, `cycles_left` equals that extra count.
- R4: For a nonzero extra count, `stall` is high from the cycle after acceptance until the final strobe. Whenever `stall` is high, `cycles_left` is nonzero.
- R5: `cycles_left` drops by exactly one on each clock edge that has `mem_strobe` high. It holds its value on edges without a strobe. A strobe in the acceptance cycle itself is not counted.
- R6: `exec_done` is a one-cycle pulse. It is high in the cycle of the strobe that completes the last extra cycle, and `stall` is low in that same cycle. For an opcode with no extra count, `exec_done` is high in its acceptance cycle.
- R7: An `op_valid` pulse in a cycle where `stall` is high is ignored: `cycles_left` continues only as the strobes dictate.
- R8: A new opcode may be accepted in the same cycle as the final strobe of the previous one. Its extra count then appears in `cycles_left` in the next cycle.
- R9: Asserting reset during a stall clears `stall` and `cycles_left` at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mem_strobe | input | 1 | One-clock pulse marking the end of a memory cycle |
| op_valid | input | 1 | Opcode presented this cycle |
| op_code | input | 8 | Fetched opcode byte |
| op_bytes | input | 2 | Instruction length in bytes (0 read as 1) |
| stall | output | 1 | Hold program counter advance |
| exec_done | output | 1 | Execution of the current instruction completes this cycle |
| cycles_left | output | 4 | Remaining memory-cycle strobes before the stall ends |

## Verification
The two functions that can coincide are the completion of one stall and the acceptance of the next opcode. Both happen in a cycle where the final `mem_strobe` and a new `op_valid` are high together. The bench drives exactly that cycle. It requires `exec_done` high and `stall` low within the cycle, and the new opcode's extra count in `cycles_left` one cycle later. A related overlap, a strobe in the acceptance cycle, is judged by checking that it does not shorten the loaded count.

// File: rtl/opst_pkg.sv
package opst_pkg;
  localparam int CNT_W       = 4;
  localparam int MAX_CYCLES  = 10;
  localparam int NUM_ENTRIES = 5;

  typedef logic [CNT_W-1:0] cnt_t;

  typedef struct packed {
    logic [7:0] code;
    cnt_t       cycles;
  } cyc_entry_t;

  localparam cyc_entry_t CYC_TABLE [NUM_ENTRIES] = '{
    '{code: 8'h13, cycles: 4'd1},
    '{code: 8'hD4, cycles: 4'd2},
    '{code: 8'h22, cycles: 4'd3},
    '{code: 8'hA4, cycles: 4'd9},
    '{code: 8'h84, cycles: 4'd10}
  };
endpackage

// File: rtl/opst_lookup.sv
module opst_lookup
  import opst_pkg::*;
(
  input  logic [7:0] code_i,
  input  logic [1:0] bytes_i,
  output cnt_t       cycles_o,
  output cnt_t       bytes_eff_o
);
  always_comb begin
    bytes_eff_o = (bytes_i == 2'd0) ? cnt_t'(1) : cnt_t'(bytes_i);
    cycles_o    = bytes_eff_o;
    for (int i = 0; i < NUM_ENTRIES; i++) begin
      if (code_i == CYC_TABLE[i].code) cycles_o = CYC_TABLE[i].cycles;
    end
  end
endmodule

// File: rtl/opst_extra.sv
module opst_extra
  import opst_pkg::*;
(
  input  cnt_t cycles_i,
  input  cnt_t bytes_i,
  output cnt_t extra_o
);
  always_comb begin
    if (cycles_i > bytes_i) extra_o = cycles_i - bytes_i;
    else                    extra_o = '0;
  end
endmodule

// File: rtl/opst_counter.sv
module opst_counter
  import opst_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic load_i,
  input  cnt_t load_val_i,
  input  logic strobe_i,
  output cnt_t count_o,
  output logic busy_o,
  output logic last_o
);
  cnt_t count_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                        count_q <= '0;
    else if (load_i)                   count_q <= load_val_i;
    else if (strobe_i && busy_o)       count_q <= count_q - cnt_t'(1);
  end

  assign count_o = count_q;
  assign busy_o  = (count_q != '0);
  assign last_o  = busy_o && strobe_i && (count_q == cnt_t'(1));

  AST_HOLD_NO_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_i && !strobe_i) |=> $stable(count_q)); // R5
  AST_DEC_ON_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_i && strobe_i && count_q != '0) |=> (count_q == $past(count_q) - cnt_t'(1))); // R5
  AST_LOAD_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |=> (count_q != '0)); // R3
endmodule

// File: rtl/opst_top.sv
module opst_top
  import opst_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       mem_strobe,
  input  logic       op_valid,
  input  logic [7:0] op_code,
  input  logic [1:0] op_bytes,
  output logic       stall,
  output logic       exec_done,
  output logic [3:0] cycles_left
);
  cnt_t cyc, bytes_eff, extra, count;
  logic busy, last, accept;

  opst_lookup u_lookup (
    .code_i(op_code), .bytes_i(op_bytes),
    .cycles_o(cyc), .bytes_eff_o(bytes_eff)
  );

  opst_extra u_extra (
    .cycles_i(cyc), .bytes_i(bytes_eff), .extra_o(extra)
  );

  opst_counter u_counter (
    .clk(clk), .rst_n(rst_n),
    .load_i(accept && (extra != '0)), .load_val_i(extra),
    .strobe_i(mem_strobe),
    .count_o(count), .busy_o(busy), .last_o(last)
  );

  assign stall       = busy && !last;
  assign accept      = op_valid && !stall;
  assign exec_done   = last || (accept && (extra == '0));
  assign cycles_left = count;

  AST_CYC_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid |-> (cyc >= cnt_t'(1) && cyc <= cnt_t'(MAX_CYCLES))); // R2
  AST_STALL_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
    stall |-> (cycles_left != '0)); // R4
  AST_DONE_NOT_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    exec_done |-> !stall); // R6
  AST_IGNORE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (stall && op_valid && !mem_strobe) |=> $stable(cycles_left)); // R7
endmodule

// File: tb/opst_top_bench.sv
module opst_top_bench;
  localparam int CLK_PERIOD = 10;

  logic clk = 0, rst_n = 0, mem_strobe = 0, op_valid = 0;
  logic [7:0] op_code = 0;
  logic [1:0] op_bytes = 0;
  logic stall, exec_done;
  logic [3:0] cycles_left;
  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  opst_top u_opst_top (
    .clk(clk), .rst_n(rst_n), .mem_strobe(mem_strobe), .op_valid(op_valid),
    .op_code(op_code), .op_bytes(op_bytes),
    .stall(stall), .exec_done(exec_done), .cycles_left(cycles_left)
  );

  // {opcode, bytes, expected extra count}  (R2, R3)
  localparam int NV = 11;
  localparam logic [13:0] VEC [NV] = '{
    {8'h13, 2'd1, 4'd0}, {8'hD4, 2'd1, 4'd1}, {8'h22, 2'd1, 4'd2},
    {8'hA4, 2'd1, 4'd8}, {8'h84, 2'd1, 4'd9}, {8'h84, 2'd3, 4'd7},
    {8'h22, 2'd3, 4'd0}, {8'hD4, 2'd3, 4'd0}, {8'h55, 2'd2, 4'd0},
    {8'hA4, 2'd2, 4'd7}, {8'h84, 2'd0, 4'd9}
  };

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic present(input logic [7:0] c, input logic [1:0] b, input logic s);
    @(negedge clk);
    op_valid = 1; op_code = c; op_bytes = b; mem_strobe = s;
    #1;
  endtask

  // strobe n times with an idle cycle between, checking each step
  task automatic drain(input int n);
    for (int i = 1; i <= n; i++) begin
      mem_strobe = 1; #1;
      chk(exec_done == (i == n), "R6 done on final strobe", exec_done, i == n);
      chk(stall == (i != n), "R4/R6 stall during strobe", stall, i != n);
      @(negedge clk); mem_strobe = 0; #1;
      chk(cycles_left == 4'(n - i), "R5 decrement per strobe", cycles_left, n - i);
      @(negedge clk); #1;
      chk(cycles_left == 4'(n - i), "R5 hold without strobe", cycles_left, n - i);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    @(negedge clk); @(negedge clk); #1;
    chk(!stall && !exec_done && cycles_left == 0, "R1 reset state", cycles_left, 0);
    rst_n = 1;
    @(negedge clk); #1;
    chk(!stall && !exec_done && cycles_left == 0, "R1 after release", stall, 0);

    // table walk: R2 R3 R4 R5 R6
    for (int v = 0; v < NV; v++) begin
      present(VEC[v][13:6], VEC[v][5:4], 1'b0);
      if (VEC[v][3:0] == 0)
        chk(exec_done && !stall, "R6 zero-extra done at accept", exec_done, 1);
      else
        chk(!exec_done, "R6 no done at accept", exec_done, 0);
      @(negedge clk); op_valid = 0; #1;
      chk(cycles_left == VEC[v][3:0], "R3 extra count loaded", cycles_left, VEC[v][3:0]);
      chk(stall == (VEC[v][3:0] != 0), "R4 stall after accept", stall, VEC[v][3:0] != 0);
      drain(int'(VEC[v][3:0]));
    end

    // R7: op_valid during stall ignored
    present(8'h22, 2'd1, 1'b0);
    @(negedge clk); op_valid = 1; op_code = 8'h84; #1;
    chk(!exec_done, "R7 ignored opcode gives no done", exec_done, 0);
    @(negedge clk); op_valid = 0; #1;
    chk(cycles_left == 2, "R7 count unchanged", cycles_left, 2);
    drain(2);

    // R5: strobe in acceptance cycle not counted
    present(8'hD4, 2'd1, 1'b1);
    @(negedge clk); op_valid = 0; mem_strobe = 0; #1;
    chk(cycles_left == 1 && stall, "R5 accept-cycle strobe ignored", cycles_left, 1);
    drain(1);

    // R8: final strobe and new accept in the same cycle
    present(8'h22, 2'd1, 1'b0);
    @(negedge clk); op_valid = 0; mem_strobe = 1; #1;
    @(negedge clk); mem_strobe = 0; #1;
    chk(cycles_left == 1, "R5 mid count", cycles_left, 1);
    mem_strobe = 1; op_valid = 1; op_code = 8'hA4; op_bytes = 2'd1; #1;
    chk(exec_done && !stall, "R8 done and accept coincide", exec_done, 1);
    @(negedge clk); mem_strobe = 0; op_valid = 0; #1;
    chk(cycles_left == 8 && stall, "R8 new count loaded", cycles_left, 8);

    // R9: reset mid-stall
    @(negedge clk); mem_strobe = 1;
    @(negedge clk); mem_strobe = 0; #1;
    rst_n = 0; #1;
    chk(cycles_left == 0 && !stall, "R9 reset clears stall", cycles_left, 0);
    @(negedge clk); rst_n = 1;
    @(negedge clk); #1;
    chk(cycles_left == 0 && !stall && !exec_done, "R9 idle after reset", cycles_left, 0);

    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule